// File: doc/BRIEF.md
# Dual-Speed 1-Wire Slave Bit Engine

This block is the bit-level physical layer of a 1-Wire slave. It watches a sampled open-drain data line through a two-flop synchronizer and times everything from one cycle counter that runs at the system clock. A low period that runs past the write-0 limit counts as a bus reset, and the block answers it with a presence pulse. Each shorter low period is a time slot. In a time slot the block samples the line at a fixed point and hands the resulting bit upward. When the layer above has armed a transmit bit of 0, the block also holds the line low through the data-valid window.

The layer above sees four things: a one-cycle reset strobe, a one-cycle received-bit strobe with its bit, and a one-cycle transmit request that marks the moment the transmit bit was taken. A speed input chooses standard or overdrive timing. The block copies it only while the bus is idle, so a slot keeps the timing it started with. The block never drives the line high. Its only output toward the line is a pull-low request.

Top module: `onewire_slave_phy`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `dq_pull`, `rx_valid`, `rst_seen` and `tx_req` are all 0.
- R2: Every falling edge on an idle line starts a slot. At 30 µs (standard) or 4 µs (overdrive) after that edge, the block samples the line and pulses `rx_valid` for one cycle. `rx_bit` is 1 if the line is high at that point and 0 if it is low.
- R3: If `tx_arm` is 1 when a slot starts, `tx_req` pulses once. When `tx_bit` is 0, `dq_pull` is 1 from the slot start until the sample point. When `tx_bit` is 1, or when `tx_arm` is 0, `dq_pull` stays 0 for the whole slot.
- R4: A low level still present 120 µs (standard) or 16 µs (overdrive) after the falling edge causes one single-cycle `rst_seen` pulse, even in the middle of a transaction. Before that, the slot's sample point has already reported one `rx_bit` of 0. `rst_seen` and `rx_valid` are never 1 in the same cycle.
- R5: After the line rises to end a reset, the block waits 30 µs and then holds `dq_pull` at 1 for 120 µs (standard). In overdrive the wait is 4 µs and the pull lasts 16 µs.
- R6: The block takes `speed_fast` (1 = overdrive) only while the bus is idle. A change during a slot does not alter that slot's sample point or reset limit. The change takes effect from the next slot.
- R7: Line activity during the presence wait or the presence pulse produces no `rx_valid` and no `rst_seen`. It also does not move or shorten the presence pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (period set by `CLK_NS`) |
| rst_n | input | 1 | Active-low asynchronous reset |
| dq_in | input | 1 | Raw level of the data line |
| speed_fast | input | 1 | 1 selects overdrive timing, 0 standard |
| tx_arm | input | 1 | Next slot is a read slot carrying `tx_bit` |
| tx_bit | input | 1 | Bit to send in an armed read slot |
| dq_pull | output | 1 | 1 pulls the data line low (open drain) |
| rst_seen | output | 1 | One-cycle strobe: bus reset detected |
| rx_valid | output | 1 | One-cycle strobe: `rx_bit` holds a slot's bit |
| rx_bit | output | 1 | Bit sampled in the latest slot |
| tx_req | output | 1 | One-cycle strobe: `tx_bit` taken at slot start |

## Verification
Two events can arrive in the same cycle: a change on the speed input and the start of a slot. The bench provokes this by flipping the speed input partway through a long standard write-0 slot. It judges the result in three ways. The bit must be sampled in the standard window. No reset strobe may appear, even though the low period is far past the overdrive reset limit. The following slot must then sample in the overdrive window. A second overlap is master activity during the presence phase. The bench places a short low pulse inside the overdrive presence wait and requires an unchanged presence pulse and no extra strobes.

// File: rtl/onewire_slave_phy.sv
module onewire_slave_phy #(
  parameter int CLK_NS        = 20,
  parameter int STD_SAMPLE_NS = 30000,
  parameter int OD_SAMPLE_NS  = 4000,
  parameter int STD_RESET_NS  = 120000,
  parameter int OD_RESET_NS   = 16000,
  parameter int STD_PDH_NS    = 30000,
  parameter int OD_PDH_NS     = 4000,
  parameter int STD_PDL_NS    = 120000,
  parameter int OD_PDL_NS     = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dq_in,
  input  logic speed_fast,
  input  logic tx_arm,
  input  logic tx_bit,
  output logic dq_pull,
  output logic rst_seen,
  output logic rx_valid,
  output logic rx_bit,
  output logic tx_req
);

  localparam int STD_SAMPLE_C = STD_SAMPLE_NS / CLK_NS;
  localparam int OD_SAMPLE_C  = OD_SAMPLE_NS / CLK_NS;
  localparam int STD_RESET_C  = STD_RESET_NS / CLK_NS;
  localparam int OD_RESET_C   = OD_RESET_NS / CLK_NS;
  localparam int STD_PDH_C    = STD_PDH_NS / CLK_NS;
  localparam int OD_PDH_C     = OD_PDH_NS / CLK_NS;
  localparam int STD_PDL_C    = STD_PDL_NS / CLK_NS;
  localparam int OD_PDL_C     = OD_PDL_NS / CLK_NS;
  localparam int CW = $clog2(STD_RESET_C + STD_PDL_C + 2) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_LOW, S_HOLD, S_RST, S_PDW, S_PDL, S_PDE
  } state_t;

  state_t        st;
  logic [1:0]    sync;
  logic          dq_s;
  logic          od;
  logic [CW-1:0] cnt;
  logic [CW-1:0] samp_c, rst_c, pdh_c, pdl_c;

  assign dq_s   = sync[1];
  assign samp_c = od ? CW'(OD_SAMPLE_C) : CW'(STD_SAMPLE_C);
  assign rst_c  = od ? CW'(OD_RESET_C)  : CW'(STD_RESET_C);
  assign pdh_c  = od ? CW'(OD_PDH_C)    : CW'(STD_PDH_C);
  assign pdl_c  = od ? CW'(OD_PDL_C)    : CW'(STD_PDL_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], dq_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      od       <= 1'b0;
      cnt      <= '0;
      dq_pull  <= 1'b0;
      rst_seen <= 1'b0;
      rx_valid <= 1'b0;
      rx_bit   <= 1'b0;
      tx_req   <= 1'b0;
    end else begin
      rst_seen <= 1'b0;
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      cnt      <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          od  <= speed_fast;
          cnt <= '0;
          if (!dq_s) begin
            st <= S_LOW;
            if (tx_arm) begin
              tx_req  <= 1'b1;
              dq_pull <= ~tx_bit;
            end
          end
        end
        S_LOW: begin
          if (cnt == samp_c) begin
            rx_valid <= 1'b1;
            rx_bit   <= dq_s;
            dq_pull  <= 1'b0;
            st       <= dq_s ? S_IDLE : S_HOLD;
          end
        end
        S_HOLD: begin
          if (dq_s) st <= S_IDLE;
          else if (cnt == rst_c) begin
            rst_seen <= 1'b1;
            st       <= S_RST;
          end
        end
        S_RST: begin
          if (dq_s) begin
            st  <= S_PDW;
            cnt <= '0;
          end
        end
        S_PDW: begin
          if (cnt == pdh_c - 1'b1) begin
            st      <= S_PDL;
            dq_pull <= 1'b1;
            cnt     <= '0;
          end
        end
        S_PDL: begin
          if (cnt == pdl_c - 1'b1) begin
            dq_pull <= 1'b0;
            st      <= S_PDE;
          end
        end
        S_PDE: begin
          if (dq_s) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_pull_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_pull |-> (st == S_LOW || st == S_PDL || st == S_PDE));

  p_txreq_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (st == S_LOW));

  p_rx_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_rst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seen |=> !rst_seen);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_seen && rx_valid));

  p_speed_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(od));

  p_presence_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PDW || st == S_PDL) |-> (!rx_valid && !rst_seen));

endmodule

// File: tb/test_onewire_slave_phy.sv
module test_onewire_slave_phy;

  localparam int SAMP_STD = 1500, SAMP_OD = 200;
  localparam int RST_STD = 6000, RST_OD = 800;
  localparam int PDH_STD = 1500, PDH_OD = 200;
  localparam int PDL_STD = 6000, PDL_OD = 800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic speed_fast = 1'b0;
  logic tx_arm = 1'b0;
  logic tx_bit = 1'b1;
  logic dq_in, dq_pull, rst_seen, rx_valid, rx_bit, tx_req;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  int n_rx, rx_at, n_tx, n_rst, rst_at, n_pull, pull_first, pull_last;
  logic rx_b;

  always #10 clk = ~clk;

  assign dq_in = ~(m_low | dq_pull);

  onewire_slave_phy i_onewire_slave_phy (
    .clk(clk), .rst_n(rst_n), .dq_in(dq_in), .speed_fast(speed_fast),
    .tx_arm(tx_arm), .tx_bit(tx_bit), .dq_pull(dq_pull), .rst_seen(rst_seen),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_req(tx_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit in_win(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  task automatic run(input int low, input int total, input int flip_at,
                     input int g_at, input int g_len);
    n_rx = 0; rx_at = -1; n_tx = 0; n_rst = 0; rst_at = -1;
    n_pull = 0; pull_first = -1; pull_last = -1; rx_b = 1'bx;
    for (int c = 0; c < total; c++) begin
      @(negedge clk);
      m_low = (c < low) || (c >= g_at && c < g_at + g_len);
      if (c == flip_at) speed_fast = ~speed_fast;
      if (rx_valid) begin n_rx++; rx_b = rx_bit; rx_at = c; end
      if (tx_req) n_tx++;
      if (rst_seen) begin n_rst++; rst_at = c; end
      if (dq_pull) begin
        n_pull++;
        if (pull_first < 0) pull_first = c;
        pull_last = c;
      end
    end
    m_low = 1'b0;
  endtask

  task automatic write_slot(input bit b, input bit fast);
    int samp = fast ? SAMP_OD : SAMP_STD;
    int low  = fast ? (b ? 50 : 500) : (b ? 250 : 4000);
    int tot  = fast ? 650 : 4500;
    run(low, tot, -1, -1, 0);
    chk(n_rx == 1, "R2 rx count", n_rx, 1);
    chk(rx_b === b, "R2 write bit", int'(rx_b), int'(b));
    chk(in_win(rx_at, samp, samp + 6), "R2 sample time", rx_at, samp);
    chk(n_pull == 0 && n_tx == 0, "R3 no drive in write slot", n_pull + n_tx, 0);
    chk(n_rst == 0, "R4 no reset in slot", n_rst, 0);
  endtask

  task automatic read_slot(input bit b, input bit fast);
    int samp = fast ? SAMP_OD : SAMP_STD;
    tx_arm = 1'b1; tx_bit = b;
    run(50, fast ? 650 : 4500, -1, -1, 0);
    tx_arm = 1'b0; tx_bit = 1'b1;
    chk(n_tx == 1, "R3 tx_req count", n_tx, 1);
    chk(rx_b === b, "R3 line bit", int'(rx_b), int'(b));
    if (b) chk(n_pull == 0, "R3 no pull for 1", n_pull, 0);
    else begin
      chk(in_win(pull_first, 2, 5), "R3 pull start", pull_first, 3);
      chk(in_win(pull_last, samp, samp + 6), "R3 pull end", pull_last, samp);
    end
  endtask

  task automatic reset_seq(input int low, input bit fast, input int g_at, input int g_len);
    int rl  = fast ? RST_OD : RST_STD;
    int pdh = fast ? PDH_OD : PDH_STD;
    int pdl = fast ? PDL_OD : PDL_STD;
    run(low, low + pdh + pdl + 600, -1, g_at, g_len);
    chk(n_rst == 1, "R4 rst_seen count", n_rst, 1);
    chk(in_win(rst_at, rl, rl + 8), "R4 reset time", rst_at, rl);
    chk(n_rx == 1 && rx_b === 1'b0, "R4 prior zero bit", n_rx, 1);
    chk(in_win(pull_first - low, pdh, pdh + 6), "R5 presence wait", pull_first - low, pdh);
    chk(in_win(pull_last - pull_first + 1, pdl - 1, pdl + 1), "R5 presence width",
        pull_last - pull_first + 1, pdl);
    chk(n_pull == pull_last - pull_first + 1, "R5 presence single", n_pull, pull_last - pull_first + 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(dq_pull == 0 && rx_valid == 0 && rst_seen == 0 && tx_req == 0, "R1 in reset",
        {dq_pull, rx_valid, rst_seen, tx_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dq_pull == 0 && rx_valid == 0 && rst_seen == 0 && tx_req == 0, "R1 after reset",
        {dq_pull, rx_valid, rst_seen, tx_req}, 0);
    repeat (5) @(negedge clk);

    speed_fast = 1'b0;
    reset_seq(25000, 1'b0, -1, 0);
    write_slot(1'b1, 1'b0);
    write_slot(1'b0, 1'b0);
    read_slot(1'b0, 1'b0);
    read_slot(1'b1, 1'b0);

    // R6: speed flips to overdrive mid-slot; slot keeps standard timing
    run(4000, 4500, 100, -1, 0);
    chk(rx_b === 1'b0 && in_win(rx_at, SAMP_STD, SAMP_STD + 6), "R6 slot keeps speed", rx_at, SAMP_STD);
    chk(n_rst == 0, "R6 no overdrive reset", n_rst, 0);
    write_slot(1'b0, 1'b1);

    // R7: master glitch inside overdrive presence wait
    reset_seq(3000, 1'b1, 3060, 20);
    chk(n_rx == 1 && n_rst == 1, "R7 glitch ignored", n_rx + n_rst, 2);

    for (int i = 0; i < 60; i++) begin
      int kind = int'($urandom % 3);
      bit b = 1'($urandom);
      if (kind == 0) read_slot(b, 1'b1);
      else write_slot(b, 1'b1);
    end

    // R4: long low in standard mode mid-transaction
    speed_fast = 1'b0;
    repeat (3) @(negedge clk);
    reset_seq(8000, 1'b0, -1, 0);
    write_slot(1'b1, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule